// File: doc/BRIEF.md
# Debug Control-Register Write Handler

This block sits behind the serial debug link of a processor core. It takes the debug command byte stream and carries out writes to the core's control registers. A command byte whose two top bits are both set asks for a control-register write, and its six low bits name the target register. Four data bytes follow, most significant first, and are packed into a 32-bit word. Every write is a full 32-bit access, even when the target register has fewer bits.

The halt status of the core is sampled when the command byte is taken. If the core is halted and the register number names an implemented register, the block issues one write strobe with the register number and the word. If the core is running, the command is illegal. The block raises a one-clock illegal flag, still consumes the four data bytes so that the stream stays aligned, and writes nothing.

The byte input is a valid/ready stream, and a byte moves only in a cycle where both valid and ready are high. The block drops ready for exactly one cycle after the fourth data byte. That cycle is the response delay in which the strobe is issued. A byte presented during that cycle has to be held by the sender until ready returns. Ready is high in every other cycle. Outside a write sequence, command bytes of any other kind are taken and have no effect. The halt input and all outputs are plain level signals.

Top module: `dbg_creg_writer`

## Requirements
- R1: After reset, in_ready is 1, and wr_en and cmd_illegal are both 0.
- R2: While idle, an accepted byte starts a write sequence only if bits [7:6] are 2'b11. Any other accepted byte is taken and ignored: it produces no strobe and no illegal flag, and the next byte is again decoded as a command.
- R3: The four data bytes that follow the command byte form wr_word. The first byte goes to bits [31:24], the second to [23:16], the third to [15:8] and the fourth to [7:0].
- R4: For a legal write, wr_en is high for exactly one clock, in the cycle right after the fourth data byte is accepted. In that cycle wr_idx holds bits [5:0] of the command byte and wr_word holds the full word.
- R5: If cpu_halted is 0 when the command byte is accepted, cmd_illegal is high for exactly one clock, in the next cycle. The four data bytes are still consumed, and no wr_en follows.
- R6: Only register numbers 0x00, 0x01, 0x02, 0x0E and 0x0F are implemented. These are the alternate stack pointer, vector base, CPU configuration, status and program counter. Any other number completes the byte sequence without a strobe and without an illegal flag.
- R7: in_ready is 0 in exactly the one cycle after the fourth data byte is accepted, and 1 otherwise. A byte offered in that cycle is not consumed.
- R8: Bytes advance the sequence only in cycles where in_valid and in_ready are both 1. Idle gaps between bytes do not change the result.
- R9: Changes of cpu_halted after the command byte has been accepted do not change whether the command is written or rejected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte stream valid |
| in_ready | output | 1 | Byte stream ready; low only in the response-delay cycle |
| in_data | input | 8 | Byte stream data |
| cpu_halted | input | 1 | Core halt status |
| wr_en | output | 1 | One-clock control-register write strobe |
| wr_idx | output | 6 | Register number of the write |
| wr_word | output | 32 | Write data |
| cmd_illegal | output | 1 | One-clock pulse when a write command is rejected |

## Verification
The assertions check, on every cycle, the following properties against a byte-position tracker of their own. The strobe only appears in the delay cycle, lasts one clock, and carries the register number captured with the command. The strobe never follows a rejected or unimplemented command. The illegal flag only appears right after a command taken while the core was running. Ready drops exactly in the delay cycle. Only the bench's scenarios can show that the data bytes land in the right byte lanes and that stray bytes in the idle state are truly ignored. The same holds for alignment after a rejected command, for stalls between bytes, and for halt changes partway through a sequence. The bench compares every cycle against a behavioural model.

// File: rtl/dbg_creg_pkg.sv
package dbg_creg_pkg;
  typedef enum logic [1:0] {
    ST_CMD  = 2'd0,
    ST_DATA = 2'd1,
    ST_DLY  = 2'd2
  } creg_state_e;
endpackage

// File: rtl/dbg_cmd_decode.sv
module dbg_cmd_decode #(
  parameter int BYTE_W = 8,
  parameter int CRN_W  = 6,
  parameter logic [(2**CRN_W)-1:0] IMPL_MASK = 64'h0000_0000_0000_C007
) (
  input  logic [BYTE_W-1:0] cmd_byte,
  output logic              is_wr,
  output logic [CRN_W-1:0]  crn,
  output logic              crn_known
);
  // tag field: every bit above the register number must be set
  assign is_wr     = &cmd_byte[BYTE_W-1:CRN_W];
  assign crn       = cmd_byte[CRN_W-1:0];
  assign crn_known = IMPL_MASK[crn];
endmodule

// File: rtl/dbg_word_shift.sv
module dbg_word_shift #(
  parameter int BYTE_W     = 8,
  parameter int DATA_BYTES = 4,
  localparam int WORD_W    = BYTE_W * DATA_BYTES,
  localparam int CNT_W     = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              shift_en,
  input  logic [BYTE_W-1:0] din,
  output logic              at_last,
  output logic [WORD_W-1:0] word
);
  logic [BYTE_W-1:0] lane [DATA_BYTES];
  logic [CNT_W-1:0]  cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (clr)      cnt <= '0;
    else if (shift_en) cnt <= cnt + 1'b1;
  end

  assign at_last = (cnt == CNT_W'(DATA_BYTES - 1));

  // lane 0 takes the newest byte; older bytes move toward the MSB lane
  for (genvar i = 0; i < DATA_BYTES; i++) begin : g_lane
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        lane[i] <= '0;
        else if (shift_en) lane[i] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        lane[i] <= '0;
        else if (shift_en) lane[i] <= lane[i-1];
      end
    end
    assign word[i*BYTE_W +: BYTE_W] = lane[i];
  end
endmodule

// File: rtl/dbg_creg_ctrl.sv
module dbg_creg_ctrl
  import dbg_creg_pkg::*;
#(
  parameter int CRN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             cpu_halted,
  input  logic             is_wr,
  input  logic [CRN_W-1:0] crn,
  input  logic             crn_known,
  input  logic             at_last,
  output logic             in_ready,
  output logic             cmd_take,
  output logic             data_take,
  output logic             wr_en,
  output logic [CRN_W-1:0] wr_idx,
  output logic             cmd_illegal
);
  creg_state_e      state;
  logic             arm_q;
  logic             ill_q;
  logic [CRN_W-1:0] crn_q;
  logic             acc;

  assign in_ready  = (state != ST_DLY);
  assign acc       = in_valid && in_ready;
  assign cmd_take  = (state == ST_CMD) && acc && is_wr;
  assign data_take = (state == ST_DATA) && acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_CMD;
      arm_q <= 1'b0;
      ill_q <= 1'b0;
      crn_q <= '0;
    end else begin
      ill_q <= 1'b0;
      unique case (state)
        ST_CMD: if (cmd_take) begin
          state <= ST_DATA;
          crn_q <= crn;
          arm_q <= cpu_halted && crn_known;
          ill_q <= !cpu_halted;
        end
        ST_DATA: if (data_take && at_last) state <= ST_DLY;
        ST_DLY:  state <= ST_CMD;
        default: state <= ST_CMD;
      endcase
    end
  end

  assign wr_en       = (state == ST_DLY) && arm_q;
  assign wr_idx      = crn_q;
  assign cmd_illegal = ill_q;
endmodule

// File: rtl/dbg_creg_writer.sv
module dbg_creg_writer #(
  parameter int BYTE_W     = 8,
  parameter int CRN_W      = 6,
  parameter int DATA_BYTES = 4,
  parameter logic [(2**CRN_W)-1:0] IMPL_MASK = 64'h0000_0000_0000_C007,
  localparam int WORD_W    = BYTE_W * DATA_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              cpu_halted,
  output logic              wr_en,
  output logic [CRN_W-1:0]  wr_idx,
  output logic [WORD_W-1:0] wr_word,
  output logic              cmd_illegal
);
  logic             is_wr, crn_known, at_last;
  logic             cmd_take, data_take;
  logic [CRN_W-1:0] crn;

  dbg_cmd_decode #(.BYTE_W(BYTE_W), .CRN_W(CRN_W), .IMPL_MASK(IMPL_MASK)) u_dec (
    .cmd_byte (in_data),
    .is_wr    (is_wr),
    .crn      (crn),
    .crn_known(crn_known)
  );

  dbg_word_shift #(.BYTE_W(BYTE_W), .DATA_BYTES(DATA_BYTES)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (cmd_take),
    .shift_en(data_take),
    .din     (in_data),
    .at_last (at_last),
    .word    (wr_word)
  );

  dbg_creg_ctrl #(.CRN_W(CRN_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .cpu_halted (cpu_halted),
    .is_wr      (is_wr),
    .crn        (crn),
    .crn_known  (crn_known),
    .at_last    (at_last),
    .in_ready   (in_ready),
    .cmd_take   (cmd_take),
    .data_take  (data_take),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .cmd_illegal(cmd_illegal)
  );
endmodule

// File: rtl/dbg_creg_writer_chk.sv
module dbg_creg_writer_chk #(
  parameter int BYTE_W     = 8,
  parameter int CRN_W      = 6,
  parameter int DATA_BYTES = 4,
  parameter logic [(2**CRN_W)-1:0] IMPL_MASK = 64'h0000_0000_0000_C007,
  localparam int K_W       = $clog2(DATA_BYTES + 2)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [BYTE_W-1:0] in_data,
  input logic              cpu_halted,
  input logic              wr_en,
  input logic [CRN_W-1:0]  wr_idx,
  input logic              cmd_illegal
);
  localparam logic [K_W-1:0] DLY_K = K_W'(DATA_BYTES + 1);

  logic [K_W-1:0]   k;
  logic             chk_halt;
  logic [CRN_W-1:0] chk_crn;
  logic             acc;

  assign acc = in_valid && in_ready;

  // independent byte-position tracker: 0 idle, 1..DATA_BYTES data, DLY_K delay
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k        <= '0;
      chk_halt <= 1'b0;
      chk_crn  <= '0;
    end else if (k == '0) begin
      if (acc && (&in_data[BYTE_W-1:CRN_W])) begin
        k        <= K_W'(1);
        chk_halt <= cpu_halted;
        chk_crn  <= in_data[CRN_W-1:0];
      end
    end else if (k == DLY_K) begin
      k <= '0;
    end else if (acc) begin
      k <= k + 1'b1;
    end
  end

  AST_STROBE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (k == DLY_K)); // R4
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en); // R4
  AST_STROBE_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx == chk_crn)); // R4
  AST_STROBE_NEEDS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> chk_halt); // R5
  AST_STROBE_KNOWN_REG: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> IMPL_MASK[chk_crn]); // R6
  AST_ILLEGAL_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_illegal |-> ((k == K_W'(1)) && !chk_halt)); // R5
  AST_NO_READY_IN_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (k == DLY_K) |-> !in_ready); // R7
  AST_READY_OUTSIDE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (k != DLY_K) |-> in_ready); // R7
endmodule

bind dbg_creg_writer dbg_creg_writer_chk #(
  .BYTE_W(BYTE_W), .CRN_W(CRN_W), .DATA_BYTES(DATA_BYTES), .IMPL_MASK(IMPL_MASK)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_data    (in_data),
  .cpu_halted (cpu_halted),
  .wr_en      (wr_en),
  .wr_idx     (wr_idx),
  .cmd_illegal(cmd_illegal)
);

// File: tb/test_dbg_creg_writer.sv
module test_dbg_creg_writer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        cpu_halted = 1'b0;
  logic        in_ready, wr_en, cmd_illegal;
  logic [5:0]  wr_idx;
  logic [31:0] wr_word;

  int vectors = 0;
  int errors  = 0;
  string scen = "R1";

  always #4 clk = ~clk;

  dbg_creg_writer i_dbg_creg_writer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .cpu_halted(cpu_halted), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_word(wr_word), .cmd_illegal(cmd_illegal)
  );

  // behavioural model: phase 0 idle, 1..4 expecting data byte, 5 delay
  int          m_phase = 0;
  int unsigned m_word  = 0;
  int          m_crn   = 0;
  bit          m_halt  = 0;
  bit          m_ill   = 0;
  int unsigned m_words[$];
  int          m_strobes = 0;
  int          d_strobes = 0;

  function automatic bit known(int crn);
    return (crn == 0) || (crn == 1) || (crn == 2) || (crn == 14) || (crn == 15);
  endfunction

  always @(posedge clk) begin
    bit acc;
    bit ill_n;
    if (!rst_n) begin
      m_phase = 0; m_ill = 0; m_word = 0; m_halt = 0; m_crn = 0;
    end else begin
      acc = in_valid && (m_phase != 5);
      ill_n = 0;
      if (wr_en) d_strobes++;
      if (m_phase == 0) begin
        if (acc && in_data[7:6] == 2'b11) begin
          m_crn = int'(in_data[5:0]); m_halt = cpu_halted;
          ill_n = !cpu_halted; m_phase = 1; m_word = 0;
        end
      end else if (m_phase == 5) begin
        m_phase = 0;
      end else if (acc) begin
        m_word = (m_word << 8) | int'(in_data);
        m_phase++;
        if (m_phase == 5 && m_halt && known(m_crn)) begin
          m_strobes++;
          m_words.push_back(m_word);
        end
      end
      m_ill = ill_n;
    end
  end

  task automatic check(string req, int got, int exp);
    vectors++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s (scenario %s) got %0h expected %0h at %0t", req, scen, got, exp, $time);
    end
  endtask

  task automatic compare();
    bit ew;
    ew = (m_phase == 5) && m_halt && known(m_crn);
    check("R7 in_ready", int'(in_ready), int'(m_phase != 5));
    check("R4 wr_en", int'(wr_en), int'(ew));
    check("R5 cmd_illegal", int'(cmd_illegal), int'(m_ill));
    if (ew) begin
      check("R4 wr_idx", int'(wr_idx), m_crn);
      check("R3 wr_word", int'(wr_word), int'(m_word));
    end
  endtask

  task automatic cyc(input bit v, input logic [7:0] d, output bit acc);
    @(negedge clk);
    compare();
    in_valid = v;
    in_data  = d;
    acc = v && (m_phase != 5);
  endtask

  task automatic push(input logic [7:0] b);
    bit a;
    do cyc(1'b1, b, a); while (!a);
  endtask

  task automatic idle(input int n);
    bit a;
    for (int i = 0; i < n; i++) cyc(1'b0, 8'h00, a);
  endtask

  task automatic wr_cmd(input logic [5:0] crn, input logic [31:0] w);
    push({2'b11, crn});
    for (int i = 3; i >= 0; i--) push(w[i*8 +: 8]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired (scenario %s)", scen);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    int unsigned lcg;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    @(negedge clk);
    check("R1 in_ready", int'(in_ready), 1);
    check("R1 wr_en", int'(wr_en), 0);
    check("R1 cmd_illegal", int'(cmd_illegal), 0);

    scen = "R4"; cpu_halted = 1'b1;
    wr_cmd(6'h0F, 32'h1234_5678); idle(2);

    scen = "R3"; // back to back, ready must drop for the delay cycle (R7)
    wr_cmd(6'h0E, 32'hA500_FF3C);
    wr_cmd(6'h00, 32'h8000_0001); idle(2);

    scen = "R5"; cpu_halted = 1'b0;
    wr_cmd(6'h01, 32'hDEAD_BEEF);
    cpu_halted = 1'b1;
    wr_cmd(6'h02, 32'h0BAD_F00D); idle(2);

    scen = "R6";
    wr_cmd(6'h05, 32'h1111_2222);
    wr_cmd(6'h3F, 32'h3333_4444); idle(2);

    scen = "R2";
    push(8'h01); push(8'h3F); push(8'hBF); push(8'h80);
    wr_cmd(6'h01, 32'h0000_00FF); idle(2);

    scen = "R8";
    push(8'hCF); idle(3); push(8'h01); idle(1); push(8'h02);
    idle(4); push(8'h03); idle(2); push(8'h04); idle(3);

    scen = "R9";
    push(8'hC2); cpu_halted = 1'b0;
    push(8'h55); push(8'h66); push(8'h77); push(8'h88);
    push(8'hC1); cpu_halted = 1'b1;
    push(8'h99); push(8'hAA); push(8'hBB); push(8'hCC); idle(2);

    scen = "R8 random";
    lcg = 32'h1357_9BDF;
    for (int n = 0; n < 300; n++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      cpu_halted = lcg[20];
      if (lcg[25:23] == 3'd0) idle(int'(lcg[27:26]));
      if (lcg[31:29] == 3'd0) push(lcg[7:0]);
      else push(lcg[11:4] | ((n % 3 == 0) ? 8'hC0 : 8'h00));
    end
    idle(8);

    scen = "R4 count";
    check("R4 strobe total", d_strobes, m_strobes);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule